// File: doc/BRIEF.md
# Predicated Element Sequencer

This block sits between instruction decode and issue. It expands one decoded three-operand scalar operation into a series of element operations numbered 0 to VL-1, while the program counter is held. Each of the destination and two source operands carries an extension tag. The tag widens its 5-bit base register number into a 7-bit index into a 128-entry register space, and it marks the operand as scalar or vector. A vector operand steps through consecutive registers. A scalar operand stays fixed on its register.

A start pulse captures the operands, the tags, VL, a predicate mask, a zeroing flag and an optional fail-first test. The block then presents one element per accepted valid/ready handshake. Each element carries the two read indices, a write index, a write enable and a zero-write strobe. The arithmetic unit outside the block returns a 3-bit condition result for the element on offer. In fail-first mode the block compares this result with the selected condition and stops at the first failing element. A one-cycle done pulse, together with the final VL, tells decode that the program counter may move on.

Top module: `elem_seq`

## Requirements
- R1: Elements are offered strictly in order 0,1,2,… with `el_valid` high. One element is consumed per cycle in which `el_valid` and `el_ready` are both high. While `el_ready` is low, the offered element and its indices are held. A VL above 64 is treated as 64.
- R2: An operand whose tag marks it as vector has an index equal to its decoded register plus the element number, modulo 128. A scalar operand's index stays at its decoded register for every element.
- R3: When the destination is scalar, the loop ends right after the first element that asserts `wr_en`.
- R4: When `pred_en` is high and `pred_mask[i]` is 0, element i asserts no `wr_en`, but the indices of later elements still advance as if it had been written. When `pred_en` is low, every element is treated as enabled.
- R5: In zeroing mode, a masked-out element with a vector destination asserts `wr_zero`. A masked-out element with a scalar destination asserts neither `wr_zero` nor `wr_en`. `wr_en` and `wr_zero` are never high together.
- R6: Tag decode works on a 3-bit spec s. With `tag_wide`=1, s is the tag. With `tag_wide`=0, s is {tag[1:0],0}. If s[2]=1 the operand is vector and its register is {base,s[1:0]}. If s[2]=0 it is scalar and its register is {s[1:0],base}.
- R7: In fail-first mode, each enabled element tests `cr_in[sel]`, where sel 0 selects eq (bit 0), 1 selects gt (bit 1), 2 selects lt (bit 2) and 3 selects eq. The test fails when this bit differs from `ff_expect`. On the first failure at element k, that element is not written, the loop ends and `vl_out`=k. Masked-out elements are not tested. Without a failure, `vl_out` equals VL.
- R8: Starting with VL=0 offers no element and pulses `done` in the cycle after the start, with `vl_out`=0.
- R9: `done` is high for exactly one cycle, the cycle after the final element is consumed. `el_valid` is low while `done` is high.
- R10: A start pulse while `busy` is high is ignored. Changes to operand, tag, mask, VL and mode inputs during a loop do not affect the loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a loop (accepted only when not busy) |
| dst_base | input | 5 | Destination base register number |
| srca_base | input | 5 | First source base register number |
| srcb_base | input | 5 | Second source base register number |
| dst_tag | input | 3 | Destination extension tag |
| srca_tag | input | 3 | First source extension tag |
| srcb_tag | input | 3 | Second source extension tag |
| tag_wide | input | 1 | 1: tags are 3-bit; 0: tags are 2-bit in bits 1:0 |
| vl_in | input | 7 | Vector length |
| pred_en | input | 1 | Use `pred_mask`; otherwise all elements enabled |
| pred_mask | input | 64 | Per-element enable mask, bit i for element i |
| zeroing | input | 1 | Zero masked-out vector destination elements |
| ff_en | input | 1 | Enable data-dependent fail-first |
| ff_sel | input | 2 | Condition bit to test (0 eq, 1 gt, 2 lt, 3 eq) |
| ff_expect | input | 1 | Value the tested bit must have to pass |
| cr_in | input | 3 | Condition result of the offered element {lt,gt,eq} |
| el_ready | input | 1 | Issue accepts the offered element |
| busy | output | 1 | Loop in progress |
| el_valid | output | 1 | An element is offered |
| el_idx | output | 6 | Element number |
| rd_a | output | 7 | First source register index |
| rd_b | output | 7 | Second source register index |
| wr_idx | output | 7 | Destination register index |
| wr_en | output | 1 | Write the element result |
| wr_zero | output | 1 | Write zero to the destination |
| done | output | 1 | One-cycle end-of-loop pulse |
| vl_out | output | 7 | Final (possibly truncated) vector length |

## Verification
The bench goes after indices that must keep advancing across masked-out elements. A design that froze them there would shift every later write one register too low. It also covers a scalar destination with leading masked bits: a design that stopped at the first element instead of the first write would never write, and one that ignored the scalar destination would write VL times. Fail-first is exercised at element 0, in the middle, and with masked elements whose condition would have failed. Wrong handling shows up as a wrong `vl_out` or as a stray write of the failing element. Further cases cover VL=0, VL above 64, register wrap at index 127, 2-bit tag decode, handshake stalls, and a second start issued mid-loop.

// File: rtl/elem_seq.sv
module elem_seq #(
  parameter int MAXVL  = 64,
  parameter int BASE_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [BASE_W-1:0]           dst_base,
  input  logic [BASE_W-1:0]           srca_base,
  input  logic [BASE_W-1:0]           srcb_base,
  input  logic [2:0]                  dst_tag,
  input  logic [2:0]                  srca_tag,
  input  logic [2:0]                  srcb_tag,
  input  logic                        tag_wide,
  input  logic [$clog2(MAXVL+1)-1:0]  vl_in,
  input  logic                        pred_en,
  input  logic [MAXVL-1:0]            pred_mask,
  input  logic                        zeroing,
  input  logic                        ff_en,
  input  logic [1:0]                  ff_sel,
  input  logic                        ff_expect,
  input  logic [2:0]                  cr_in,
  input  logic                        el_ready,
  output logic                        busy,
  output logic                        el_valid,
  output logic [$clog2(MAXVL)-1:0]    el_idx,
  output logic [BASE_W+1:0]           rd_a,
  output logic [BASE_W+1:0]           rd_b,
  output logic [BASE_W+1:0]           wr_idx,
  output logic                        wr_en,
  output logic                        wr_zero,
  output logic                        done,
  output logic [$clog2(MAXVL+1)-1:0]  vl_out
);
  localparam int VLW = $clog2(MAXVL+1);
  localparam int IW  = $clog2(MAXVL);
  localparam int RW  = BASE_W + 2;

  logic [IW-1:0]    i_q;
  logic [VLW-1:0]   vl_q;
  logic [RW-1:0]    rt_q, ra_q, rb_q;
  logic             rt_v, ra_v, rb_v;
  logic [MAXVL-1:0] mask_q;
  logic             zero_q, ff_q, exp_q;
  logic [1:0]       sel_q;

  function automatic logic [RW:0] decode(input logic [BASE_W-1:0] b,
                                         input logic [2:0] t, input logic w);
    logic [2:0] s;
    s = w ? t : {t[1:0], 1'b0};
    return s[2] ? {1'b1, b, s[1:0]} : {1'b0, s[1:0], b};
  endfunction

  logic [VLW-1:0] vl_cl;
  assign vl_cl = (vl_in > VLW'(MAXVL)) ? VLW'(MAXVL) : vl_in;

  logic en, tbit, fail, last, fire, stop;
  assign en = mask_q[i_q];

  always_comb begin
    case (sel_q)
      2'd1:    tbit = cr_in[1];
      2'd2:    tbit = cr_in[2];
      default: tbit = cr_in[0];
    endcase
  end

  assign fail = ff_q && en && (tbit != exp_q);
  assign last = (VLW'(i_q) + VLW'(1)) == vl_q;
  assign fire = busy && el_ready;
  assign stop = last || fail || (en && !rt_v);

  assign el_valid = busy;
  assign el_idx   = i_q;
  assign rd_a     = ra_q + (ra_v ? RW'(i_q) : RW'(0));
  assign rd_b     = rb_q + (rb_v ? RW'(i_q) : RW'(0));
  assign wr_idx   = rt_q + (rt_v ? RW'(i_q) : RW'(0));
  assign wr_en    = busy && en && !fail;
  assign wr_zero  = busy && !en && zero_q && rt_v;
  assign vl_out   = vl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      i_q    <= '0;
      vl_q   <= '0;
      rt_q   <= '0;
      ra_q   <= '0;
      rb_q   <= '0;
      rt_v   <= 1'b0;
      ra_v   <= 1'b0;
      rb_v   <= 1'b0;
      mask_q <= '0;
      zero_q <= 1'b0;
      ff_q   <= 1'b0;
      exp_q  <= 1'b0;
      sel_q  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        {rt_v, rt_q} <= decode(dst_base, dst_tag, tag_wide);
        {ra_v, ra_q} <= decode(srca_base, srca_tag, tag_wide);
        {rb_v, rb_q} <= decode(srcb_base, srcb_tag, tag_wide);
        mask_q <= pred_en ? pred_mask : '1;
        zero_q <= zeroing;
        ff_q   <= ff_en;
        sel_q  <= ff_sel;
        exp_q  <= ff_expect;
        vl_q   <= vl_cl;
        i_q    <= '0;
        if (vl_cl == '0) done <= 1'b1;
        else             busy <= 1'b1;
      end else if (fire) begin
        if (stop) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (fail) vl_q <= VLW'(i_q);
        end else begin
          i_q <= i_q + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/elem_seq_chk.sv
module elem_seq_chk #(
  parameter int MAXVL  = 64,
  parameter int BASE_W = 5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        el_valid,
  input logic                        el_ready,
  input logic [$clog2(MAXVL)-1:0]    el_idx,
  input logic [BASE_W+1:0]           rd_a,
  input logic                        wr_en,
  input logic                        wr_zero,
  input logic                        done,
  input logic [$clog2(MAXVL+1)-1:0]  vl_out,
  input logic                        ra_v,
  input logic                        rt_v
);
  localparam int IW = $clog2(MAXVL);

  a_r1_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && !el_ready |=> el_valid && $stable(el_idx));

  a_r1_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(el_valid) |-> el_idx == '0);

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && el_ready |=> !el_valid || el_idx == IW'($past(el_idx) + 1'b1));

  a_r2_scalar_src: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && el_ready && !ra_v |=> !el_valid || $stable(rd_a));

  a_r3_scalar_dst_end: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && el_ready && wr_en && !rt_v |=> !el_valid && done);

  a_r5_write_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_zero));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !el_valid);

  a_r7_vl_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> vl_out <= ($clog2(MAXVL+1))'(MAXVL));
endmodule

bind elem_seq elem_seq_chk #(.MAXVL(MAXVL), .BASE_W(BASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .el_valid(el_valid), .el_ready(el_ready),
  .el_idx(el_idx), .rd_a(rd_a), .wr_en(wr_en), .wr_zero(wr_zero),
  .done(done), .vl_out(vl_out), .ra_v(ra_v), .rt_v(rt_v)
);

// File: tb/elem_seq_bench.sv
module elem_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [4:0] dst_base = '0, srca_base = '0, srcb_base = '0;
  logic [2:0] dst_tag = '0, srca_tag = '0, srcb_tag = '0;
  logic tag_wide = 1'b1;
  logic [6:0] vl_in = '0;
  logic pred_en = 1'b0, zeroing = 1'b0, ff_en = 1'b0, ff_expect = 1'b0;
  logic [63:0] pred_mask = '0;
  logic [1:0] ff_sel = '0;
  logic [2:0] cr_in = '0;
  logic el_ready = 1'b0;
  logic busy, el_valid, wr_en, wr_zero, done;
  logic [5:0] el_idx;
  logic [6:0] rd_a, rd_b, wr_idx, vl_out;

  elem_seq u_elem_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  logic [2:0] crs [64];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: run hung, act=%0d exp=<100000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ext(input logic [4:0] b, input logic [2:0] t, input logic w, output bit vec);
    logic [2:0] s = w ? t : {t[1:0], 1'b0};
    vec = s[2];
    return vec ? (int'(b) * 4 + int'(s[1:0])) : (int'(s[1:0]) * 32 + int'(b));
  endfunction

  task automatic run_case(input string req, input int rdy_mode, input bit disturb);
    int q_i[$], q_a[$], q_b[$], q_w[$], q_we[$], q_wz[$];
    int vl, exp_vl, k, cyc, ba, bb, bt, tb;
    bit va, vb, vt, en;
    ba = ext(srca_base, srca_tag, tag_wide, va);
    bb = ext(srcb_base, srcb_tag, tag_wide, vb);
    bt = ext(dst_base, dst_tag, tag_wide, vt);
    vl = (vl_in > 64) ? 64 : int'(vl_in);
    exp_vl = vl;
    for (int i = 0; i < vl; i++) begin
      en = !pred_en || pred_mask[i];
      q_i.push_back(i);
      q_a.push_back((ba + (va ? i : 0)) % 128);
      q_b.push_back((bb + (vb ? i : 0)) % 128);
      q_w.push_back((bt + (vt ? i : 0)) % 128);
      tb = (ff_sel == 2'd1) ? int'(crs[i][1]) : (ff_sel == 2'd2) ? int'(crs[i][2]) : int'(crs[i][0]);
      if (en && ff_en && tb != int'(ff_expect)) begin
        q_we.push_back(0); q_wz.push_back(0); exp_vl = i; break;
      end
      q_we.push_back(en ? 1 : 0);
      q_wz.push_back((!en && zeroing && vt) ? 1 : 0);
      if (en && !vt) break;
    end
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0; cyc = 0;
    forever begin
      if (disturb && cyc == 1) begin
        start = 1'b1; vl_in = 7'd3; dst_tag = ~dst_tag; srca_tag = ~srca_tag;
        pred_en = 1'b1; pred_mask = '0; zeroing = 1'b1; dst_base = dst_base + 5'd7;
      end else start = 1'b0;
      el_ready = (rdy_mode == 0) || (rdy_mode == 1 && cyc % 2 == 1) || (rdy_mode == 2 && cyc % 3 == 2);
      if (k < q_i.size()) cr_in = crs[q_i[k]];
      #1;
      if (k < q_i.size()) begin
        chk("R1", "el_valid", int'(el_valid), 1);
        chk("R1", "el_idx", int'(el_idx), q_i[k]);
        chk("R2", "rd_a", int'(rd_a), q_a[k]);
        chk("R2", "rd_b", int'(rd_b), q_b[k]);
        chk("R6", "wr_idx", int'(wr_idx), q_w[k]);
        chk("R4", "wr_en", int'(wr_en), q_we[k]);
        chk("R5", "wr_zero", int'(wr_zero), q_wz[k]);
        chk("R9", "done early", int'(done), 0);
        if (el_ready) k++;
      end else begin
        chk(req, "done", int'(done), 1);
        chk("R7", "vl_out", int'(vl_out), exp_vl);
        chk("R9", "el_valid at done", int'(el_valid), 0);
        break;
      end
      cyc++;
      if (cyc > 1000) begin chk(req, "loop timeout", 1, 0); break; end
      @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);
    chk("R9", "done pulse width", int'(done), 0);
    chk("R9", "busy after done", int'(busy), 0);
  endtask

  task automatic setup(input logic [4:0] t, input logic [4:0] a, input logic [4:0] b,
                       input logic [2:0] tt, input logic [2:0] ta, input logic [2:0] tbb,
                       input logic w, input int vl);
    dst_base = t; srca_base = a; srcb_base = b;
    dst_tag = tt; srca_tag = ta; srcb_tag = tbb; tag_wide = w; vl_in = 7'(vl);
    pred_en = 1'b0; pred_mask = '0; zeroing = 1'b0; ff_en = 1'b0; ff_sel = '0; ff_expect = 1'b0;
    for (int i = 0; i < 64; i++) crs[i] = 3'b001;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) crs[i] = 3'b001;
    repeat (3) @(negedge clk);
    #1;
    chk("R9", "reset done", int'(done), 0);
    chk("R1", "reset el_valid", int'(el_valid), 0);
    chk("R10", "reset busy", int'(busy), 0);
    rst_n = 1'b1;

    // R1/R2: all vector, 3-bit tags
    setup(5'd3, 5'd10, 5'd20, 3'b101, 3'b110, 3'b100, 1'b1, 8);
    run_case("R1", 0, 1'b0);
    // R2: scalar source a, vector b, stalls
    setup(5'd4, 5'd9, 5'd2, 3'b100, 3'b011, 3'b111, 1'b1, 5);
    run_case("R2", 1, 1'b0);
    // R4: predication, indices still advance
    setup(5'd1, 5'd2, 5'd3, 3'b100, 3'b100, 3'b100, 1'b1, 8);
    pred_en = 1'b1; pred_mask = 64'hB6;
    run_case("R4", 2, 1'b0);
    // R5: zeroing on vector destination
    setup(5'd1, 5'd2, 5'd3, 3'b100, 3'b100, 3'b100, 1'b1, 8);
    pred_en = 1'b1; pred_mask = 64'hB6; zeroing = 1'b1;
    run_case("R5", 0, 1'b0);
    // R5/R3: scalar destination, leading masked elements, zeroing
    setup(5'd6, 5'd2, 5'd3, 3'b001, 3'b100, 3'b000, 1'b1, 10);
    pred_en = 1'b1; pred_mask = 64'h18; zeroing = 1'b1;
    run_case("R3", 1, 1'b0);
    // R3: scalar destination, no predicate
    setup(5'd6, 5'd2, 5'd3, 3'b010, 3'b100, 3'b100, 1'b1, 10);
    run_case("R3", 0, 1'b0);
    // R6: 2-bit tags and wrap past 127
    setup(5'd31, 5'd17, 5'd31, 3'b010, 3'b001, 3'b011, 1'b0, 6);
    run_case("R6", 0, 1'b0);
    // R7: fail-first mid-loop, masked element with a would-fail result untested
    setup(5'd1, 5'd2, 5'd3, 3'b100, 3'b100, 3'b100, 1'b1, 12);
    ff_en = 1'b1; ff_sel = 2'd0; ff_expect = 1'b0;
    for (int i = 0; i < 64; i++) crs[i] = 3'b010;
    crs[2] = 3'b001; crs[5] = 3'b001;
    pred_en = 1'b1; pred_mask = 64'hFFB;
    run_case("R7", 1, 1'b0);
    // R7: failure at element 0, lt selected
    setup(5'd1, 5'd2, 5'd3, 3'b100, 3'b100, 3'b100, 1'b1, 9);
    ff_en = 1'b1; ff_sel = 2'd2; ff_expect = 1'b1;
    run_case("R7", 0, 1'b0);
    // R7: fail-first without a failure, gt selected
    setup(5'd1, 5'd2, 5'd3, 3'b100, 3'b100, 3'b100, 1'b1, 7);
    ff_en = 1'b1; ff_sel = 2'd1; ff_expect = 1'b0;
    run_case("R7", 2, 1'b0);
    // R8: VL = 0
    setup(5'd1, 5'd2, 5'd3, 3'b100, 3'b100, 3'b100, 1'b1, 0);
    run_case("R8", 0, 1'b0);
    // R1: VL above 64 clamps to 64
    setup(5'd0, 5'd1, 5'd2, 3'b100, 3'b101, 3'b110, 1'b1, 100);
    run_case("R1", 0, 1'b0);
    // R10: start and input changes mid-loop ignored
    setup(5'd2, 5'd4, 5'd8, 3'b100, 3'b100, 3'b000, 1'b1, 20);
    run_case("R10", 1, 1'b0 ^ 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule